// File: doc/BRIEF.md
# Clocked Synchronous Serial Transmitter

This block sends bytes over a clocked synchronous serial link. A host places a byte in a holding register and clears the buffer-empty flag. The block then moves the byte into a shift register and sends it least significant bit first, one bit per serial clock. It adds no start, stop or parity bits. The serial clock is either made inside the block by dividing the system clock, or taken from an external clock input. In the external case the input passes through a two-flop synchroniser, and its edges are detected in the system clock domain.

The holding register gives the host a full frame time to supply the next byte. While the last bit of a frame is on the line, the block looks at the buffer-empty flag. If a new byte is waiting, it is loaded and the next frame follows with no gap in the clock. If no byte is waiting, the block raises a transmit-end flag and parks the data line at the level of that last bit. An internally driven serial clock then rests high. Two interrupt requests are provided, one for buffer empty and one for transmit end, the second behind its own enable. A transmit enable gates the whole block.

Top module: `sync_serial_tx`

## Requirements
- R1: After reset, with `tx_en` low, `sdata` = 1, `sclk_out` = 1, `buf_empty` = 1, `tx_end` = 1 and `irq_empty` = 0.
- R2: Each frame is NBITS (8) data bits, bit 0 first and bit NBITS-1 last. `sdata` changes only together with a falling edge of the serial clock and is stable at the next rising edge. With the internal clock each frame has exactly NBITS low-going pulses, and each half period is DIV_HALF system cycles.
- R3: If the host refills the buffer (write plus `clr_empty`) before or during the cycle in which the last bit is put on the line, the next frame follows with no gap: consecutive rising edges of `sclk_out` stay 2*DIV_HALF cycles apart across the frame boundary.
- R4: If the buffer is still empty when the last bit is put out, `tx_end` goes to 1. After the final rising edge `sclk_out` stays 1, and `sdata` keeps the value of that last bit until the next frame starts.
- R5: `irq_end` = `tx_end` AND `tend_ie` AND `tx_en`; with `tend_ie` = 0 it is never raised.
- R6: `irq_empty` = `buf_empty` AND `tx_en`. A `wr_stb` while `buf_empty` = 1 stores `wr_data`. A `clr_empty` pulse while `buf_empty` = 1 clears `buf_empty` and `tx_end`. Only that pulse clears `buf_empty`, which returns to 1 when the byte moves into the shift register.
- R7: A `wr_stb` while `buf_empty` = 0 is ignored: the byte already waiting is the one that is sent.
- R8: While `tx_en` = 0, `buf_empty` and `tx_end` are forced to 1, the shift register and bit position are cleared, `sdata` = 1, `sclk_out` = 1, and writes and clears are ignored. A frame in flight is abandoned.
- R9: With `ext_sel` = 1, `sclk_out` stays 1. Bits advance on falling edges of `sclk_in`, one bit per pulse, after a synchronisation delay of about three system cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable; low clears and idles the block |
| ext_sel | input | 1 | 1 selects the external serial clock `sclk_in` |
| sclk_in | input | 1 | External serial clock (asynchronous) |
| wr_stb | input | 1 | Host write strobe for the holding register |
| wr_data | input | NBITS | Byte to store |
| clr_empty | input | 1 | Host pulse that clears the buffer-empty flag |
| tend_ie | input | 1 | Transmit-end interrupt enable |
| sclk_out | output | 1 | Serial clock output, idles high |
| sdata | output | 1 | Serial data output |
| buf_empty | output | 1 | Holding register empty flag |
| tx_end | output | 1 | Transmission ended flag |
| irq_empty | output | 1 | Buffer-empty interrupt request |
| irq_end | output | 1 | Transmit-end interrupt request |

## Verification
A wrong bit position or a bad shift-register load shows as a wrong byte at the receiver. The mismatch appears by the rising edge that samples the faulty bit, at most one frame after the error. A wrong refill decision at the last bit shows within one serial half period, either as a stretched clock gap or as a `tx_end` that rises during a burst. An enable or buffer flag that is stuck shows on `buf_empty` or `irq_empty` one cycle after the host action that should have changed it.

// File: rtl/sync_serial_tx.sv
module sync_serial_tx #(
  parameter int NBITS    = 8,
  parameter int DIV_HALF = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic             ext_sel,
  input  logic             sclk_in,
  input  logic             wr_stb,
  input  logic [NBITS-1:0] wr_data,
  input  logic             clr_empty,
  input  logic             tend_ie,
  output logic             sclk_out,
  output logic             sdata,
  output logic             buf_empty,
  output logic             tx_end,
  output logic             irq_empty,
  output logic             irq_end
);
  localparam int CW = (NBITS > 1) ? $clog2(NBITS) : 1;
  localparam int DW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

  logic [NBITS-1:0] hold_q, shift_q;
  logic [CW-1:0]    bit_q;
  logic [DW-1:0]    div_q;
  logic [2:0]       sync_q;
  logic             active_q, last_q, sclk_q, dout_q;

  logic div_wrap, int_tick, fall_ev, rise_ev, start, last_bit, refill;
  logic [NBITS-1:0] next_hold;

  assign div_wrap  = (div_q == DW'(DIV_HALF - 1));
  assign int_tick  = active_q & ~ext_sel & div_wrap;
  assign fall_ev   = ext_sel ? (active_q & sync_q[2] & ~sync_q[1]) : (int_tick & sclk_q);
  assign rise_ev   = ext_sel ? (active_q & ~sync_q[2] & sync_q[1]) : (int_tick & ~sclk_q);
  assign start     = ~active_q & ~buf_empty;
  assign last_bit  = (bit_q == CW'(NBITS - 1));
  assign refill    = ~buf_empty | clr_empty;
  assign next_hold = (wr_stb & buf_empty) ? wr_data : hold_q;

  assign sclk_out  = ext_sel ? 1'b1 : sclk_q;
  assign sdata     = dout_q;
  assign irq_empty = buf_empty & tx_en;
  assign irq_end   = tx_end & tend_ie & tx_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 3'b111;
    else        sync_q <= {sync_q[1:0], sclk_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      sclk_q <= 1'b1;
    end else if (!tx_en || !active_q || ext_sel) begin
      div_q  <= '0;
      sclk_q <= 1'b1;
    end else if (div_wrap) begin
      div_q  <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      div_q  <= div_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q    <= '0;
      shift_q   <= '0;
      bit_q     <= '0;
      active_q  <= 1'b0;
      last_q    <= 1'b0;
      dout_q    <= 1'b1;
      buf_empty <= 1'b1;
      tx_end    <= 1'b1;
    end else if (!tx_en) begin
      shift_q   <= '0;
      bit_q     <= '0;
      active_q  <= 1'b0;
      last_q    <= 1'b0;
      dout_q    <= 1'b1;
      buf_empty <= 1'b1;
      tx_end    <= 1'b1;
    end else begin
      if (wr_stb && buf_empty) hold_q <= wr_data;
      if (clr_empty && buf_empty) begin
        buf_empty <= 1'b0;
        tx_end    <= 1'b0;
      end
      if (start) begin
        shift_q   <= hold_q;
        buf_empty <= 1'b1;
        bit_q     <= '0;
        active_q  <= 1'b1;
        last_q    <= 1'b0;
      end else if (fall_ev && !last_q) begin
        dout_q <= shift_q[bit_q];
        if (last_bit) begin
          bit_q <= '0;
          if (refill) begin
            shift_q   <= next_hold;
            buf_empty <= 1'b1;
          end else begin
            last_q <= 1'b1;
            tx_end <= 1'b1;
          end
        end else begin
          bit_q <= bit_q + 1'b1;
        end
      end else if (rise_ev && last_q) begin
        active_q <= 1'b0;
        last_q   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sync_serial_tx_chk.sv
module sync_serial_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_en,
  input logic ext_sel,
  input logic clr_empty,
  input logic tend_ie,
  input logic sclk_out,
  input logic sdata,
  input logic buf_empty,
  input logic tx_end,
  input logic irq_end
);
  a_r8_disable_forces_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> (buf_empty && sdata && sclk_out));

  a_r9_ext_clock_high: assert property (@(posedge clk) disable iff (!rst_n)
    ext_sel |-> sclk_out);

  a_r4_line_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_end && $past(tx_end) && tx_en && $past(tx_en)) |-> $stable(sdata));

  a_r6_only_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_empty && tx_en && !clr_empty) |=> buf_empty);

  a_r6_pending_not_ended: assert property (@(posedge clk) disable iff (!rst_n)
    !buf_empty |-> !tx_end);

  a_r5_masked_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    !tend_ie |-> !irq_end);
endmodule

bind sync_serial_tx sync_serial_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .ext_sel(ext_sel),
  .clr_empty(clr_empty), .tend_ie(tend_ie), .sclk_out(sclk_out),
  .sdata(sdata), .buf_empty(buf_empty), .tx_end(tx_end), .irq_end(irq_end)
);

// File: tb/test_sync_serial_tx.sv
module test_sync_serial_tx;
  localparam int NB = 8;
  localparam int DH = 4;
  localparam int EXTH = 8;

  logic clk = 1'b0, rst_n = 1'b0, tx_en = 1'b0, ext_sel = 1'b0, sclk_in = 1'b1;
  logic wr_stb = 1'b0, clr_empty = 1'b0, tend_ie = 1'b0;
  logic [NB-1:0] wr_data = '0;
  logic sclk_out, sdata, buf_empty, tx_end, irq_empty, irq_end;

  sync_serial_tx #(.NBITS(NB), .DIV_HALF(DH)) i_sync_serial_tx (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .ext_sel(ext_sel), .sclk_in(sclk_in),
    .wr_stb(wr_stb), .wr_data(wr_data), .clr_empty(clr_empty), .tend_ie(tend_ie),
    .sclk_out(sclk_out), .sdata(sdata), .buf_empty(buf_empty), .tx_end(tx_end),
    .irq_empty(irq_empty), .irq_end(irq_end));

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int cyc = 0, rises = 0, last_rise = 0, gmin = 0, gmax = 0, viol = 0, nb = 0;
  logic [NB-1:0] sh = '0;
  logic [NB-1:0] rxq[$];
  logic [NB-1:0] sent[$];
  logic p_sclk = 1'b1, p_sdata = 1'b1, p_en = 1'b0;

  function automatic bit exp_irq_end(bit te, bit ie, bit en);
    return te & ie & en;
  endfunction

  function automatic bit exp_last_bit(logic [NB-1:0] b);
    return b[NB-1];
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!ext_sel && p_sclk === 1'b0 && sclk_out === 1'b1) begin
      if (rises > 0) begin
        if (cyc - last_rise < gmin || gmin == 0) gmin = cyc - last_rise;
        if (cyc - last_rise > gmax) gmax = cyc - last_rise;
      end
      last_rise = cyc;
      rises++;
      sh = {sdata, sh[NB-1:1]};
      nb++;
      if (nb == NB) begin rxq.push_back(sh); nb = 0; end
    end
    if (!ext_sel && tx_en && p_en && sdata !== p_sdata && !(p_sclk === 1'b1 && sclk_out === 1'b0))
      viol++;
    p_sclk = sclk_out; p_sdata = sdata; p_en = tx_en;
  end

  task automatic mon_clear();
    rises = 0; gmin = 0; gmax = 0; viol = 0; nb = 0; sh = '0;
    rxq.delete(); sent.delete();
  endtask

  task automatic put_byte(logic [NB-1:0] b);
    while (!buf_empty) @(negedge clk);
    wr_stb = 1'b1; clr_empty = 1'b1; wr_data = b;
    @(negedge clk);
    wr_stb = 1'b0; clr_empty = 1'b0;
    sent.push_back(b);
  endtask

  task automatic wait_end();
    int guard = 0;
    while (!(tx_end && sclk_out) && guard < 5000) begin @(negedge clk); guard++; end
    repeat (2 * DH + 3) @(negedge clk);
  endtask

  task automatic cmp_bytes(string req);
    check({req, " byte count"}, rxq.size(), sent.size());
    foreach (sent[i]) if (i < rxq.size()) check({req, " byte"}, rxq[i], sent[i]);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [NB-1:0] b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 sdata", sdata, 1);
    check("R1 sclk_out", sclk_out, 1);
    check("R1 buf_empty", buf_empty, 1);
    check("R1 tx_end", tx_end, 1);
    check("R1 irq_empty", irq_empty, 0);

    tx_en = 1'b1; tend_ie = 1'b1;
    @(negedge clk);
    check("R6 irq_empty idle", irq_empty, 1);

    // R2/R4/R5 single frame
    mon_clear();
    put_byte(8'hA5);
    wait_end();
    cmp_bytes("R2");
    check("R2 pulses", rises, NB);
    check("R2 half period", gmin, 2 * DH);
    check("R2 change on fall", viol, 0);
    check("R4 tx_end", tx_end, 1);
    check("R4 sclk rest", sclk_out, 1);
    check("R4 line held", sdata, exp_last_bit(8'hA5));
    check("R5 irq_end on", irq_end, exp_irq_end(tx_end, tend_ie, tx_en));
    tend_ie = 1'b0;
    @(negedge clk);
    check("R5 irq_end masked", irq_end, 0);

    // R3 back-to-back
    mon_clear();
    put_byte(8'h3C); put_byte(8'h81); put_byte(8'h7E);
    wait_end();
    cmp_bytes("R3");
    check("R3 pulses", rises, 3 * NB);
    check("R3 min gap", gmin, 2 * DH);
    check("R3 max gap", gmax, 2 * DH);
    check("R4 line held after burst", sdata, exp_last_bit(8'h7E));

    // R7 write while not empty is ignored
    mon_clear();
    put_byte(8'h11); put_byte(8'h46);
    check("R7 flag pending", buf_empty, 0);
    check("R6 irq_empty low", irq_empty, 0);
    wr_stb = 1'b1; wr_data = 8'hFF;
    @(negedge clk);
    wr_stb = 1'b0;
    wait_end();
    cmp_bytes("R7");

    // R8 disable mid-frame
    mon_clear();
    put_byte(8'hF0);
    repeat (6 * DH) @(negedge clk);
    tx_en = 1'b0;
    @(negedge clk);
    check("R8 buf_empty", buf_empty, 1);
    check("R8 sdata", sdata, 1);
    check("R8 sclk_out", sclk_out, 1);
    check("R8 tx_end", tx_end, 1);
    check("R8 irq_empty", irq_empty, 0);
    wr_stb = 1'b1; clr_empty = 1'b1; wr_data = 8'h55;
    @(negedge clk);
    wr_stb = 1'b0; clr_empty = 1'b0;
    @(negedge clk);
    check("R8 clear ignored", buf_empty, 1);
    tx_en = 1'b1;
    @(negedge clk);
    mon_clear();
    put_byte(8'h0F);
    wait_end();
    cmp_bytes("R8 restart");

    // R9 external clock
    begin
      logic [NB-1:0] xs;
      logic [NB-1:0] xq[$];
      int low_seen;
      ext_sel = 1'b1; low_seen = 0; xs = '0;
      mon_clear();
      put_byte(8'h6B); put_byte(8'hD2);
      repeat (4) @(negedge clk);
      for (int k = 0; k < 2 * NB; k++) begin
        sclk_in = 1'b0;
        for (int j = 0; j < EXTH; j++) begin
          @(negedge clk);
          if (!sclk_out) low_seen++;
        end
        xs = {sdata, xs[NB-1:1]};
        if (k % NB == NB - 1) xq.push_back(xs);
        sclk_in = 1'b1;
        for (int j = 0; j < EXTH; j++) begin
          @(negedge clk);
          if (!sclk_out) low_seen++;
        end
      end
      check("R9 sclk_out high", low_seen, 0);
      check("R9 frames", xq.size(), 2);
      check("R9 byte 0", xq[0], 8'h6B);
      check("R9 byte 1", xq[1], 8'hD2);
      check("R9 tx_end", tx_end, 1);
      check("R9 line held", sdata, exp_last_bit(8'hD2));
      ext_sel = 1'b0;
      repeat (3) @(negedge clk);
    end

    // R2/R3/R5 random bursts
    for (int it = 0; it < 20; it++) begin
      int n;
      n = 1 + int'($urandom(1000 + it) % 3);
      tend_ie = 1'($urandom() & 1);
      mon_clear();
      for (int k = 0; k < n; k++) begin
        b0 = NB'($urandom());
        put_byte(b0);
      end
      wait_end();
      cmp_bytes("R2 random");
      if (n > 1) check("R3 random gap", gmax, 2 * DH);
      check("R4 random hold", sdata, exp_last_bit(b0));
      check("R5 random irq", irq_end, exp_irq_end(tx_end, tend_ie, tx_en));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule